// File: doc/BRIEF.md
# Indirect Register Window Interrupt Table

This block is the register front end of an I/O interrupt controller. Software sees only two 32-bit locations. The first, at offset 0x00, is an 8-bit select register. The second, at offset 0x10, is a data window. The select value decides what the window reaches: the controller ID register, a read-only version word, an arbitration ID word, or one 32-bit half of a 64-bit routing entry. The routing table holds one entry per interrupt input pin. It resets with every pin masked.

The whole table is driven out to the delivery logic. When a bus write changes a pin's mask bit, the block raises a one-cycle strobe that carries the pin index. The delivery logic owns each entry's remote-pending flag (bit 14). It sets the flag through a per-pin set input. Any write to the lower half of an entry clears that flag.

Each entry has these fields:
- vector in bits 7:0
- delivery mode in bits 10:8
- destination mode in bit 11
- remote-pending flag in bit 14
- trigger mode in bit 15 (1 = level)
- mask in bit 16
- destination in bits 63:56

Read data is combinational on the bus address and the current state. A write takes effect at the clock edge where `busWr` is high.

Top module: `irq_window_top`

## Requirements
- R1: After reset, the select register and the ID are zero. Every entry reads 0x0001_0000 in its lower half (only the mask, bit 16, set) and zero in its upper half. The mask strobe is low.
- R2: A write at offset 0x00 stores data bits 7:0 as the select value, and a read at 0x00 returns it zero-extended. A read at any offset other than 0x00 and 0x10 returns zero, and a write there changes nothing.
- R3: With select 0x01, the window reads (NUM_PINS−1) in bits 23:16 and VERSION_CODE in bits 7:0, with the other bits zero. A write there has no effect.
- R4: With select 0x00, a window write stores data bits 27:24 as the ID. Select 0x00 and select 0x02 both read the ID in bits 27:24, with the other bits zero. A window write with select 0x02 is ignored.
- R5: For a select value S of 0x10 or more, the window reaches entry (S−0x10)>>1. Its upper 32 bits are reached when S is odd and its lower 32 bits when S is even. Each half is written and read back independently.
- R6: A window read returns 0xFFFF_FFFF, and a window write is ignored, when the entry index is NUM_PINS or more, or when the select value is in 0x03..0x0F.
- R7: A write to an entry's lower half leaves its bit 14 at zero, whatever the written data holds in bit 14. A write to the upper half leaves bit 14 unchanged.
- R8: A high `remoteSet[i]` sets bit 14 of entry i at the next edge. If a lower-half write to entry i falls in the same cycle, the clear wins.
- R9: A window write that changes an entry's mask bit makes `maskChg` high for exactly the following cycle, with `maskIdx` holding the entry index. A write that leaves the mask unchanged gives no strobe.
- R10: `tableOut[64*i +: 64]` always equals the current contents of entry i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | 8 | Register offset |
| busWr | input | 1 | Write enable |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, combinational on busAddr |
| remoteSet | input | NUM_PINS | Per-pin set of the remote-pending flag |
| tableOut | output | 64*NUM_PINS | Flattened table contents, entry i at bits 64*i+63:64*i |
| maskChg | output | 1 | One-cycle strobe after a mask bit toggles |
| maskIdx | output | IDX_W | Entry index that goes with maskChg |

## Verification
The bench builds the block with its defaults: NUM_PINS = 24 and VERSION_CODE = 0x11. With 24 pins, the last valid entry sits at select 0x3E/0x3F and the first out-of-range index at select 0x40. Both are reached directly, so the boundary between valid and all-ones reads is exercised on both sides. The version word's pin-count field then reads 0x17, which pins down the minus-one encoding.

// File: rtl/irq_window_pkg.sv
package irq_window_pkg;

  // Bus offsets
  localparam logic [7:0] OFF_SEL = 8'h00;
  localparam logic [7:0] OFF_WIN = 8'h10;

  // Select values
  localparam logic [7:0] SEL_ID  = 8'h00;
  localparam logic [7:0] SEL_VER = 8'h01;
  localparam logic [7:0] SEL_ARB = 8'h02;
  localparam logic [7:0] SEL_TBL = 8'h10;

  // Entry field positions
  localparam int F_REMOTE = 14;
  localparam int F_MASK   = 16;

  localparam int ENT_W = 64;
  localparam logic [ENT_W-1:0] ENTRY_RESET = 64'h0000_0000_0001_0000;

  // Strobes from control to the table datapath
  typedef struct packed {
    logic        entWr;  // window write to a valid entry
    logic        hi;     // upper half selected
    logic [6:0]  idx;    // entry index derived from select
    logic [31:0] data;   // write data
  } winStrb_t;

endpackage

// File: rtl/irq_window_ctrl.sv
module irq_window_ctrl
  import irq_window_pkg::*;
#(
  parameter int         NUM_PINS     = 24,
  parameter logic [7:0] VERSION_CODE = 8'h11
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  busAddr,
  input  logic        busWr,
  input  logic [31:0] busWrData,
  input  logic [31:0] entRd,
  output winStrb_t    strb,
  output logic [31:0] busRdData
);

  logic [7:0] selReg;
  logic [3:0] idReg;
  logic       winHit;
  logic       selHit;
  logic       tblSel;
  logic [7:0] rawIdx;
  logic [31:0] winRd;

  assign selHit = (busAddr == OFF_SEL);
  assign winHit = (busAddr == OFF_WIN);
  assign tblSel = (selReg >= SEL_TBL);
  assign rawIdx = (selReg - SEL_TBL) >> 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      selReg <= '0;
      idReg  <= '0;
    end else if (busWr) begin
      if (selHit) selReg <= busWrData[7:0];
      if (winHit && selReg == SEL_ID) idReg <= busWrData[27:24];
    end
  end

  always_comb begin
    strb.entWr = busWr && winHit && tblSel && (rawIdx < 8'(NUM_PINS));
    strb.hi    = selReg[0];
    strb.idx   = rawIdx[6:0];
    strb.data  = busWrData;
  end

  always_comb begin
    if (tblSel) begin
      winRd = entRd;
    end else begin
      case (selReg)
        SEL_ID, SEL_ARB: winRd = {4'b0, idReg, 24'b0};
        SEL_VER:         winRd = {8'b0, 8'(NUM_PINS - 1), 8'b0, VERSION_CODE};
        default:         winRd = '1;
      endcase
    end
  end

  always_comb begin
    if (selHit)      busRdData = {24'b0, selReg};
    else if (winHit) busRdData = winRd;
    else             busRdData = '0;
  end

  // R2: select register only moves on a write at its own offset
  a_r2_sel_hold: assert property (@(posedge clk) disable iff (rst)
    !(busWr && busAddr == OFF_SEL) |=> $stable(selReg));

  // R4: ID only moves on a window write with the ID selected
  a_r4_id_hold: assert property (@(posedge clk) disable iff (rst)
    !(busWr && busAddr == OFF_WIN && selReg == SEL_ID) |=> $stable(idReg));

  // R6: no table write strobe while a non-table select is active
  a_r6_no_oob_strobe: assert property (@(posedge clk) disable iff (rst)
    (selReg < SEL_TBL) |-> !strb.entWr);

endmodule

// File: rtl/irq_window_table.sv
module irq_window_table
  import irq_window_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  winStrb_t                  strb,
  input  logic [NUM_PINS-1:0]       remoteSet,
  output logic [31:0]               entRd,
  output logic [NUM_PINS*ENT_W-1:0] tableOut,
  output logic                      maskChg,
  output logic [IDX_W-1:0]          maskIdx
);

  logic [ENT_W-1:0]    tbl     [NUM_PINS];
  logic [ENT_W-1:0]    tblNext [NUM_PINS];
  logic [NUM_PINS-1:0] toggled;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_ent
    always_comb begin
      tblNext[i] = tbl[i];
      if (remoteSet[i]) tblNext[i][F_REMOTE] = 1'b1;
      if (strb.entWr && strb.idx == 7'(i)) begin
        if (strb.hi) begin
          tblNext[i][63:32] = strb.data;
        end else begin
          tblNext[i][31:0]     = strb.data;
          tblNext[i][F_REMOTE] = 1'b0;
        end
      end
    end

    assign toggled[i] = tblNext[i][F_MASK] != tbl[i][F_MASK];

    always_ff @(posedge clk) begin
      if (rst) tbl[i] <= ENTRY_RESET;
      else     tbl[i] <= tblNext[i];
    end

    assign tableOut[ENT_W*i +: ENT_W] = tbl[i];

    // R7: a lower-half write leaves the remote-pending flag clear
    a_r7_lo_clears_remote: assert property (@(posedge clk) disable iff (rst)
      (strb.entWr && !strb.hi && strb.idx == 7'(i)) |=> !tbl[i][F_REMOTE]);

    // R8: the set input takes effect unless a lower-half write collides
    a_r8_remote_set: assert property (@(posedge clk) disable iff (rst)
      (remoteSet[i] && !(strb.entWr && !strb.hi && strb.idx == 7'(i)))
        |=> tbl[i][F_REMOTE]);

    // R9: a mask change is always reported with its index
    a_r9_mask_strobe: assert property (@(posedge clk) disable iff (rst)
      (tbl[i][F_MASK] != $past(tbl[i][F_MASK])) |-> (maskChg && maskIdx == IDX_W'(i)));

    // R5: an entry is stable without a write or set aimed at it
    a_r5_entry_stable: assert property (@(posedge clk) disable iff (rst)
      !(remoteSet[i] || (strb.entWr && strb.idx == 7'(i))) |=> $stable(tbl[i]));
  end

  always_comb begin
    entRd = '1;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (strb.idx == 7'(i)) entRd = strb.hi ? tbl[i][63:32] : tbl[i][31:0];
    end
  end

  logic [IDX_W-1:0] togIdx;
  always_comb begin
    togIdx = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (toggled[i]) togIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      maskChg <= 1'b0;
      maskIdx <= '0;
    end else begin
      maskChg <= |toggled;
      maskIdx <= togIdx;
    end
  end

endmodule

// File: rtl/irq_window_top.sv
module irq_window_top
  import irq_window_pkg::*;
#(
  parameter int         NUM_PINS     = 24,
  parameter logic [7:0] VERSION_CODE = 8'h11,
  localparam int        IDX_W        = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [7:0]             busAddr,
  input  logic                   busWr,
  input  logic [31:0]            busWrData,
  output logic [31:0]            busRdData,
  input  logic [NUM_PINS-1:0]    remoteSet,
  output logic [NUM_PINS*64-1:0] tableOut,
  output logic                   maskChg,
  output logic [IDX_W-1:0]       maskIdx
);

  winStrb_t    strb;
  logic [31:0] entRd;

  irq_window_ctrl #(
    .NUM_PINS(NUM_PINS),
    .VERSION_CODE(VERSION_CODE)
  ) u_ctrl (
    .clk(clk),
    .rst(rst),
    .busAddr(busAddr),
    .busWr(busWr),
    .busWrData(busWrData),
    .entRd(entRd),
    .strb(strb),
    .busRdData(busRdData)
  );

  irq_window_table #(
    .NUM_PINS(NUM_PINS)
  ) u_table (
    .clk(clk),
    .rst(rst),
    .strb(strb),
    .remoteSet(remoteSet),
    .entRd(entRd),
    .tableOut(tableOut),
    .maskChg(maskChg),
    .maskIdx(maskIdx)
  );

endmodule

// File: tb/irq_window_top_tb.sv
module irq_window_top_tb;

  localparam int NP = 24;
  localparam int IW = $clog2(NP);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [7:0]        busAddr = '0;
  logic              busWr = 1'b0;
  logic [31:0]       busWrData = '0;
  logic [31:0]       busRdData;
  logic [NP-1:0]     remoteSet = '0;
  logic [NP*64-1:0]  tableOut;
  logic              maskChg;
  logic [IW-1:0]     maskIdx;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  irq_window_top #(.NUM_PINS(NP), .VERSION_CODE(8'h11)) u_dut (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWr(busWr),
    .busWrData(busWrData), .busRdData(busRdData), .remoteSet(remoteSet),
    .tableOut(tableOut), .maskChg(maskChg), .maskIdx(maskIdx)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic winRead(input logic [7:0] s, output logic [31:0] d);
    busWrite(8'h00, {24'b0, s});
    busRead(8'h10, d);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    busRead(8'h00, d);             chk("R1 select", d, 0);
    winRead(8'h00, d);             chk("R1 id", d, 0);
    winRead(8'h10, d);             chk("R1 entry0 lo", d, 32'h0001_0000);
    winRead(8'h11, d);             chk("R1 entry0 hi", d, 0);
    chk("R1 maskChg", maskChg, 0);
    chk("R10 entry 23 out", tableOut[64*23 +: 64], 64'h0000_0000_0001_0000);
  endtask

  task automatic t_offsets;
    logic [31:0] d;
    busWrite(8'h00, 32'hFFFF_FF2A);
    busRead(8'h00, d);             chk("R2 select 8 bits", d, 32'h2A);
    busWrite(8'h20, 32'h1234_5678);
    busRead(8'h00, d);             chk("R2 other offset write ignored", d, 32'h2A);
    busRead(8'h20, d);             chk("R2 other offset reads zero", d, 0);
  endtask

  task automatic t_version;
    logic [31:0] d;
    winRead(8'h01, d);             chk("R3 version", d, 32'h0017_0011);
    busWrite(8'h10, 32'hFFFF_FFFF);
    busRead(8'h10, d);             chk("R3 version write ignored", d, 32'h0017_0011);
  endtask

  task automatic t_id;
    logic [31:0] d;
    busWrite(8'h00, 32'h0);
    busWrite(8'h10, 32'hA5FF_FFFF);
    busRead(8'h10, d);             chk("R4 id write", d, 32'h0500_0000);
    winRead(8'h02, d);             chk("R4 arb reads id", d, 32'h0500_0000);
    busWrite(8'h10, 32'h0C00_0000);
    winRead(8'h00, d);             chk("R4 arb write ignored", d, 32'h0500_0000);
  endtask

  task automatic t_entries;
    logic [31:0] d;
    busWrite(8'h00, 32'h3F);
    busWrite(8'h10, 32'hDEAD_BEEF);
    chk("R9 no strobe on hi write", maskChg, 0);
    busWrite(8'h00, 32'h3E);
    busWrite(8'h10, 32'h0000_C0F1);
    chk("R9 strobe", maskChg, 1);
    chk("R9 index", maskIdx, 23);
    @(negedge clk);
    chk("R9 strobe one cycle", maskChg, 0);
    busRead(8'h10, d);             chk("R7 lo clears remote", d, 32'h0000_80F1);
    winRead(8'h3F, d);             chk("R5 entry23 hi", d, 32'hDEAD_BEEF);
    chk("R10 table out 23", tableOut[64*23 +: 64], 64'hDEAD_BEEF_0000_80F1);
    winRead(8'h3D, d);             chk("R5 entry22 untouched", d, 0);
  endtask

  task automatic t_oob;
    logic [31:0] d;
    logic [NP*64-1:0] snap;
    snap = tableOut;
    winRead(8'h40, d);             chk("R6 index past end", d, 32'hFFFF_FFFF);
    busWrite(8'h10, 32'h0);
    chk("R6 oob write ignored", tableOut == snap, 1);
    chk("R6 oob no strobe", maskChg, 0);
    winRead(8'h05, d);             chk("R6 gap select", d, 32'hFFFF_FFFF);
    busWrite(8'h10, 32'h0);
    chk("R6 gap write ignored", tableOut == snap, 1);
  endtask

  task automatic t_remote;
    logic [31:0] d;
    @(negedge clk); remoteSet[3] = 1'b1;
    @(negedge clk); remoteSet[3] = 1'b0;
    winRead(8'h16, d);             chk("R8 set", d, 32'h0001_4000);
    busWrite(8'h00, 32'h17);
    busWrite(8'h10, 32'h0000_00FF);
    winRead(8'h16, d);             chk("R7 hi write keeps remote", d, 32'h0001_4000);
    busWrite(8'h10, 32'h0001_4000);
    chk("R9 unchanged mask no strobe", maskChg, 0);
    busRead(8'h10, d);             chk("R7 lo write clears", d, 32'h0001_0000);
    busWrite(8'h00, 32'h1A);
    @(negedge clk);
    busAddr = 8'h10; busWrData = 32'h0001_0000; busWr = 1'b1; remoteSet[5] = 1'b1;
    @(negedge clk);
    busWr = 1'b0; remoteSet[5] = 1'b0;
    busRead(8'h10, d);             chk("R8 write wins collision", d, 32'h0001_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_offsets();
    t_version();
    t_id();
    t_entries();
    t_oob();
    t_remote();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule